// File: doc/BRIEF.md
# DMA Event Status and Interrupt Summary Register

This block holds the event status word of a network controller's DMA engine. The transmit and receive DMA processes report events as single-cycle pulses. Each pulse sets a sticky bit that stays high until software writes a one to that bit position. Two summary bits, one normal and one abnormal, are fixed ORs of chosen event groups. They are recomputed every cycle from the sticky bits. A single interrupt line combines the two summaries through two enable inputs. The same read word also shows the current 3-bit transmit and receive process state codes. A change of state code never raises an interrupt.

A parity error, master abort or target abort on the bus sets a fatal status bit. It also latches a bus-access-disable output that tells the bus master to stop all traffic. Software can clear the fatal status bit by writing a one to it, but the disable stays asserted until a software reset. A software reset returns every latched bit and the disable to zero in one cycle. The register port is a single word: the read data is combinational, and a write strobe carries the clear mask.

Top module: `dis_status_reg`

## Requirements
- R1: A pulse on `evt_i[k]`, for k in {0,1,2,3,5,6,7,8,9,11}, sets read bit k at the next clock edge. The bit stays set while no clear arrives.
- R2: A write with `wr_data_i[k]`=1 clears latched bit k at the next edge. A 0 in a write leaves the bit unchanged.
- R3: If an event and a write-one clear hit the same bit in the same cycle, the bit ends up set.
- R4: Read bit 16 (normal summary) is the OR of latched bits 0, 2 and 6. It follows them at once and ignores writes.
- R5: Read bit 15 (abnormal summary) is the OR of latched bits 1, 3, 5, 7, 8, 9, 11 and 13. It follows them at once and ignores writes.
- R6: Read bits 22:20 always equal `tx_state_i`, and read bits 19:17 always equal `rx_state_i`, in the same cycle. A state change alone never changes `irq_o`.
- R7: Any of `par_err_i`, `mst_abort_i` or `tgt_abort_i` sets read bit 13 and `bus_dis_o` at the next edge.
- R8: `bus_dis_o` stays high after bit 13 is cleared by a write. Only a software reset drops it.
- R9: A `soft_rst` cycle clears all latched bits and `bus_dis_o` at the next edge. This holds even if events or bus errors arrive in that same cycle.
- R10: `irq_o` = (bit 16 AND `irq_en_norm_i`) OR (bit 15 AND `irq_en_abn_i`).
- R11: Read bits 4, 10, 12, 14 and 31:23 are always 0. `evt_i[4]`, `evt_i[10]` and writes to those positions have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| soft_rst | input | 1 | Synchronous software reset |
| evt_i | input | 12 | Event pulses; bit k targets status bit k |
| par_err_i | input | 1 | Bus parity error pulse |
| mst_abort_i | input | 1 | Bus master abort pulse |
| tgt_abort_i | input | 1 | Bus target abort pulse |
| tx_state_i | input | 3 | Transmit process state code |
| rx_state_i | input | 3 | Receive process state code |
| wr_en_i | input | 1 | Write strobe (write-one-to-clear) |
| wr_data_i | input | 32 | Write data / clear mask |
| irq_en_norm_i | input | 1 | Enable of the normal summary into irq_o |
| irq_en_abn_i | input | 1 | Enable of the abnormal summary into irq_o |
| rd_data_o | output | 32 | Status word read value |
| irq_o | output | 1 | Interrupt request |
| bus_dis_o | output | 1 | Bus access disable |

## Verification
Each of the twelve event inputs is pulsed alone under all four enable combinations. A lone bit shows which summary group a position belongs to, shows the interrupt gating, and exposes the two unused inputs. Groups of bits are then cleared one by one, so each summary must stay high until its last contributor is gone. All 64 transmit/receive state pairs are swept to show the fields pass through and never touch the interrupt. Each bus-error source is driven on its own to show the disable outlasting the status clear. Collisions of a set with a clear, and of events with a software reset, fix the two priority rules.

// File: rtl/dis_pkg.sv
`timescale 1ns/1ps
package dis_pkg;
  localparam int STS_W     = 16;
  localparam int EV_W      = 12;
  localparam int ST_W      = 3;
  localparam int FATAL_BIT = 13;
  localparam int ABN_BIT   = 15;
  localparam int NRM_BIT   = 16;
  localparam int RX_LSB    = 17;
  localparam int TX_LSB    = 20;
  localparam int USED_W    = TX_LSB + ST_W;

  // contributors of each summary; their union is the set of latching positions
  localparam logic [STS_W-1:0] NRM_GRP    = 16'h0045;
  localparam logic [STS_W-1:0] ABN_GRP    = 16'h2BAA;
  localparam logic [STS_W-1:0] LATCH_MASK = NRM_GRP | ABN_GRP;

  typedef enum logic [ST_W-1:0] {
    TX_IDLE = 3'd0, TX_FETCH = 3'd1, TX_SEND = 3'd2, TX_FILL = 3'd3,
    TX_RSV4 = 3'd4, TX_RSV5 = 3'd5, TX_PARK = 3'd6, TX_CLOSE = 3'd7
  } tx_state_e;

  typedef enum logic [ST_W-1:0] {
    RX_IDLE = 3'd0, RX_FETCH = 3'd1, RX_CHECK = 3'd2, RX_WAIT = 3'd3,
    RX_PARK = 3'd4, RX_CLOSE = 3'd5, RX_FLUSH = 3'd6, RX_DRAIN = 3'd7
  } rx_state_e;

  function automatic logic group_any(input logic [STS_W-1:0] sts,
                                     input logic [STS_W-1:0] grp);
    return |(sts & grp);
  endfunction

  function automatic logic [USED_W-1:0] pack_word(
      input logic [ST_W-1:0] tx, input logic [ST_W-1:0] rx,
      input logic nrm, input logic abn, input logic [STS_W-1:0] sts);
    logic [USED_W-1:0] w;
    w = '0;
    w[ABN_BIT-1:0]          = sts[ABN_BIT-1:0] & LATCH_MASK[ABN_BIT-1:0];
    w[ABN_BIT]              = abn;
    w[NRM_BIT]              = nrm;
    w[RX_LSB +: ST_W]       = rx;
    w[TX_LSB +: ST_W]       = tx;
    return w;
  endfunction
endpackage

// File: rtl/dis_sticky_bank.sv
`timescale 1ns/1ps
module dis_sticky_bank #(
  parameter int W = 16,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         soft_rst,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  logic unused_inputs;
  assign unused_inputs = ^((set_i | clr_i) & ~MASK);

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (MASK[i]) begin : g_flop
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        q <= 1'b0;
        else if (soft_rst) q <= 1'b0;
        else if (set_i[i]) q <= 1'b1;
        else if (clr_i[i]) q <= 1'b0;
      end
      assign q_o[i] = q;
    end else begin : g_tie
      assign q_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/dis_fatal_guard.sv
`timescale 1ns/1ps
module dis_fatal_guard (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst,
  input  logic par_err_i,
  input  logic mst_abort_i,
  input  logic tgt_abort_i,
  output logic fatal_evt_o,
  output logic bus_dis_o
);
  assign fatal_evt_o = par_err_i | mst_abort_i | tgt_abort_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           bus_dis_o <= 1'b0;
    else if (soft_rst)    bus_dis_o <= 1'b0;
    else if (fatal_evt_o) bus_dis_o <= 1'b1;
  end
endmodule

// File: rtl/dis_summary.sv
`timescale 1ns/1ps
module dis_summary
  import dis_pkg::*;
(
  input  logic [STS_W-1:0] sts_i,
  input  logic             en_norm_i,
  input  logic             en_abn_i,
  output logic             nrm_o,
  output logic             abn_o,
  output logic             irq_o
);
  assign nrm_o = group_any(sts_i, NRM_GRP);
  assign abn_o = group_any(sts_i, ABN_GRP);
  assign irq_o = (nrm_o & en_norm_i) | (abn_o & en_abn_i);
endmodule

// File: rtl/dis_status_reg.sv
`timescale 1ns/1ps
module dis_status_reg
  import dis_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic [EV_W-1:0]  evt_i,
  input  logic             par_err_i,
  input  logic             mst_abort_i,
  input  logic             tgt_abort_i,
  input  logic [ST_W-1:0]  tx_state_i,
  input  logic [ST_W-1:0]  rx_state_i,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             irq_en_norm_i,
  input  logic             irq_en_abn_i,
  output logic [REG_W-1:0] rd_data_o,
  output logic             irq_o,
  output logic             bus_dis_o
);
  localparam int PAD_W = REG_W - USED_W;

  logic             fatal_evt;
  logic [STS_W-1:0] set_vec;
  logic [STS_W-1:0] clr_vec;
  logic [STS_W-1:0] sts_q;
  logic             nrm_sum;
  logic             abn_sum;
  logic             unused_wr_hi;

  assign unused_wr_hi = ^wr_data_i[REG_W-1:STS_W];

  always_comb begin
    set_vec            = '0;
    set_vec[EV_W-1:0]  = evt_i;
    set_vec[FATAL_BIT] = fatal_evt;
    clr_vec            = wr_en_i ? wr_data_i[STS_W-1:0] : '0;
  end

  dis_fatal_guard u_fatal (
    .clk         (clk),
    .rst_n       (rst_n),
    .soft_rst    (soft_rst),
    .par_err_i   (par_err_i),
    .mst_abort_i (mst_abort_i),
    .tgt_abort_i (tgt_abort_i),
    .fatal_evt_o (fatal_evt),
    .bus_dis_o   (bus_dis_o)
  );

  dis_sticky_bank #(.W(STS_W), .MASK(LATCH_MASK)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_rst (soft_rst),
    .set_i    (set_vec),
    .clr_i    (clr_vec),
    .q_o      (sts_q)
  );

  dis_summary u_sum (
    .sts_i     (sts_q),
    .en_norm_i (irq_en_norm_i),
    .en_abn_i  (irq_en_abn_i),
    .nrm_o     (nrm_sum),
    .abn_o     (abn_sum),
    .irq_o     (irq_o)
  );

  if (PAD_W > 0) begin : g_pad
    assign rd_data_o = {{PAD_W{1'b0}},
                        pack_word(tx_state_i, rx_state_i, nrm_sum, abn_sum, sts_q)};
  end else begin : g_nopad
    assign rd_data_o = pack_word(tx_state_i, rx_state_i, nrm_sum, abn_sum, sts_q);
  end
endmodule

// File: rtl/dis_status_chk.sv
`timescale 1ns/1ps
module dis_status_chk
  import dis_pkg::*;
#(
  parameter int REG_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             soft_rst,
  input logic [EV_W-1:0]  evt_i,
  input logic             wr_en_i,
  input logic [REG_W-1:0] wr_data_i,
  input logic             fatal_evt,
  input logic             irq_en_norm_i,
  input logic             irq_en_abn_i,
  input logic [REG_W-1:0] rd_data_o,
  input logic             irq_o,
  input logic             bus_dis_o
);
  // R1
  evt_sets_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i[0] && !soft_rst) |=> rd_data_o[0]);
  // R2
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data_o[6] && !soft_rst && !(wr_en_i && wr_data_i[6])) |=> rd_data_o[6]);
  // R3
  set_beats_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i[3] && wr_en_i && wr_data_i[3] && !soft_rst) |=> rd_data_o[3]);
  // R7
  fatal_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fatal_evt && !soft_rst) |=> (bus_dis_o && rd_data_o[13]));
  // R8
  dis_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_dis_o && !soft_rst) |=> bus_dis_o);
  // R9
  soft_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (rd_data_o[16:0] == 17'd0 && !bus_dis_o));
  // R10
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == ((rd_data_o[16] && irq_en_norm_i) || (rd_data_o[15] && irq_en_abn_i)));
  // R11
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data_o[4] | rd_data_o[10] | rd_data_o[12] | rd_data_o[14] |
     (|rd_data_o[REG_W-1:USED_W])) == 1'b0);
endmodule

bind dis_status_reg dis_status_chk #(.REG_W(REG_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .soft_rst      (soft_rst),
  .evt_i         (evt_i),
  .wr_en_i       (wr_en_i),
  .wr_data_i     (wr_data_i),
  .fatal_evt     (fatal_evt),
  .irq_en_norm_i (irq_en_norm_i),
  .irq_en_abn_i  (irq_en_abn_i),
  .rd_data_o     (rd_data_o),
  .irq_o         (irq_o),
  .bus_dis_o     (bus_dis_o)
);

// File: tb/dis_status_reg_test.sv
`timescale 1ns/1ps
module dis_status_reg_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_rst = 1'b0;
  logic [11:0] evt_i = '0;
  logic        par_err_i = 1'b0, mst_abort_i = 1'b0, tgt_abort_i = 1'b0;
  logic [2:0]  tx_state_i = '0, rx_state_i = '0;
  logic        wr_en_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic        irq_en_norm_i = 1'b0, irq_en_abn_i = 1'b0;
  logic [31:0] rd_data_o;
  logic        irq_o, bus_dis_o;

  int applied = 0;
  int bad = 0;
  bit done = 0;
  logic [15:0] m_sts = '0;
  logic        m_dis = 1'b0;

  always #4 clk = ~clk;

  dis_status_reg uut (.*);

  function automatic bit latching(int b);
    return b inside {0, 1, 2, 3, 5, 6, 7, 8, 9, 11, 13};
  endfunction

  function automatic logic [31:0] want_rd();
    logic [31:0] e = '0;
    for (int b = 0; b < 14; b++) if (latching(b)) e[b] = m_sts[b];
    e[16] = m_sts[0] | m_sts[2] | m_sts[6];
    e[15] = m_sts[1] | m_sts[3] | m_sts[5] | m_sts[7] | m_sts[8] |
            m_sts[9] | m_sts[11] | m_sts[13];
    e[19:17] = rx_state_i;
    e[22:20] = tx_state_i;
    return e;
  endfunction

  task automatic check(input string tag);
    logic [31:0] e = want_rd();
    logic ei = (e[16] & irq_en_norm_i) | (e[15] & irq_en_abn_i);
    applied++;
    if (rd_data_o !== e) begin
      bad++; $display("FAIL %s rd_data actual=%h expected=%h", tag, rd_data_o, e);
    end
    if (irq_o !== ei) begin
      bad++; $display("FAIL %s irq actual=%b expected=%b", tag, irq_o, ei);
    end
    if (bus_dis_o !== m_dis) begin
      bad++; $display("FAIL %s bus_dis actual=%b expected=%b", tag, bus_dis_o, m_dis);
    end
  endtask

  task automatic step(input logic [11:0] ev, input logic [2:0] err,
                      input logic we, input logic [31:0] wd, input logic sr);
    logic fat = |err;
    evt_i = ev; {par_err_i, mst_abort_i, tgt_abort_i} = err;
    wr_en_i = we; wr_data_i = wd; soft_rst = sr;
    @(posedge clk);
    if (sr) begin
      m_sts = '0; m_dis = 1'b0;
    end else begin
      for (int b = 0; b < 14; b++) if (latching(b)) begin
        if ((b == 13) ? fat : ev[b]) m_sts[b] = 1'b1;
        else if (we && wd[b])       m_sts[b] = 1'b0;
      end
      if (fat) m_dis = 1'b1;
    end
    #1;
    evt_i = '0; {par_err_i, mst_abort_i, tgt_abort_i} = '0;
    wr_en_i = 1'b0; wr_data_i = '0; soft_rst = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 check("R11 reset");
    rst_n = 1'b1;
    @(posedge clk); #1 check("R9 after reset");

    // R1 R4 R5 R10 R11: each event alone, all enable combinations, then R2 clear
    for (int k = 0; k < 12; k++) begin
      for (int en = 0; en < 4; en++) begin
        {irq_en_norm_i, irq_en_abn_i} = en[1:0];
        step(12'(1 << k), 3'b000, 1'b0, '0, 1'b0);
        check("R1 R10 single event");
        step('0, 3'b000, 1'b0, '0, 1'b0);
        check("R1 hold");
        step('0, 3'b000, 1'b1, 32'(1 << k), 1'b0);
        check("R2 clear one");
      end
    end
    irq_en_norm_i = 1'b1; irq_en_abn_i = 1'b1;

    // R2: writing zeros leaves bits alone
    step(12'hFFF, 3'b000, 1'b0, '0, 1'b0);
    check("R1 all events");
    step('0, 3'b000, 1'b1, 32'h0, 1'b0);
    check("R2 write zero");
    // R4 R5 R11: writes to summary/reserved positions ignored
    step('0, 3'b000, 1'b1, 32'hFFFF_0000 | 32'h0001_D410, 1'b0);
    check("R11 R4 R5 write reserved");
    // R4: normal summary falls only after the last contributor is cleared
    step('0, 3'b000, 1'b1, 32'h0000_0005, 1'b0);
    check("R4 bit6 keeps summary");
    step('0, 3'b000, 1'b1, 32'h0000_0040, 1'b0);
    check("R4 normal summary falls");
    // R5: abnormal summary falls in stages
    step('0, 3'b000, 1'b1, 32'h0000_03AA, 1'b0);
    check("R5 bit11 keeps summary");
    step('0, 3'b000, 1'b1, 32'h0000_0800, 1'b0);
    check("R5 abnormal summary falls");

    // R3: set beats simultaneous clear
    step(12'h008, 3'b000, 1'b1, 32'h0000_0008, 1'b0);
    check("R3 set wins");
    step('0, 3'b000, 1'b1, 32'h0000_0008, 1'b0);
    check("R2 clear after collision");

    // R6: state field sweep, irq untouched
    for (int t = 0; t < 8; t++)
      for (int r = 0; r < 8; r++) begin
        tx_state_i = 3'(t); rx_state_i = 3'(r);
        #1 check("R6 state fields");
      end

    // R7 R8 R9: each bus error source
    for (int s = 0; s < 3; s++) begin
      step('0, 3'(1 << s), 1'b0, '0, 1'b0);
      check("R7 fatal latch");
      step('0, 3'b000, 1'b1, 32'h0000_2000, 1'b0);
      check("R8 disable outlives status clear");
      step('0, 3'b000, 1'b0, '0, 1'b0);
      check("R8 disable holds");
      step('0, 3'b000, 1'b0, '0, 1'b1);
      check("R9 soft reset drops disable");
    end

    // R9: soft reset wins over same-cycle events and errors
    step(12'hFFF, 3'b000, 1'b0, '0, 1'b0);
    check("R1 refill");
    step(12'hFFF, 3'b111, 1'b0, '0, 1'b1);
    check("R9 soft reset priority");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end
endmodule